// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO controller

This block is a 32-pin general-purpose I/O controller on a plain 32-bit register bus that has separate read and write strobes, a byte address and write data. Software selects, pin by pin, whether a pin is driven from the data register or sampled as an input. Input pins pass through a synchroniser and feed a per-pin interrupt detector. Each input pin can watch for a low level, a high level, a rising edge or a falling edge. An optional any-edge select overrides that choice.

The status bits are gated by a mask and combined into interrupt request lines. A build parameter chooses the layout of those lines: one line that covers all 32 pins, or two lines that each cover 16 pins. A second build parameter decides whether the any-edge register exists. Reads return data one cycle after the read strobe. An access to an offset the block does not decode raises an error flag for one cycle.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register holds zero, `pin_oe` and `pin_out` are zero and both `irq` bits are low.
- R2: `pin_oe` equals the direction register (offset 0x04, 1 = output) and `pin_out` equals data register (offset 0x00) AND direction.
- R3: A read returns its value on `bus_rdata` in the cycle after `bus_rd`. Reading offset 0x00 gives the data bit for output pins and the pad level for input pins. Reading offset 0x08 (read-only) gives the pad level of input pins, with output-pin bits read as zero.
- R4: Pin n has a 2-bit mode at bits [2n+1:2n] of the 64-bit value {mode-high (0x10), mode-low (0x0C)}. Mode 00 is active-low level and mode 01 is active-high level. A level pin keeps its status bit (offset 0x18) set for as long as its synchronised input sits at the active level.
- R5: Mode 10 sets status on a rising edge and mode 11 on a falling edge. An edge is a difference between the newest synchronised sample and the stored pad level. A pin change driven before clock edge 1 is visible in status and `irq` after clock edge 3.
- R6: In the build with the any-edge register (offset 0x1C), a 1 in bit n makes every transition of pin n set status, whatever the mode of pin n.
- R7: Pins whose direction bit is 1 never set a status bit.
- R8: Status is write-one-to-clear. Zero bits in the written word leave status alone. When a level pin is still active, its hardware set wins over a clear in the same cycle.
- R9: Without split mode, `irq[0]` is the OR over (status AND mask (0x14)) and `irq[1]` is 0. With split mode, `irq[0]` covers bits 15:0 and `irq[1]` covers bits 31:16.
- R10: A write to the direction, mode or any-edge register takes effect on detection in the next cycle. A level pin already at its new active level sets status at once, and an edge-mode pin sets nothing from the write.
- R11: In the build without the any-edge register, offset 0x1C reads zero, writes to it change nothing, and accesses to it raise `bus_err`.
- R12: An access that is not word aligned or that falls outside 0x00–0x1C changes no state. A read of such an offset returns zero, and `bus_err` is high for exactly the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle flag for an undecoded access |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| irq | output | 2 | Interrupt request lines |

## Verification
The bench builds two copies that share every input. One copy uses the defaults (any-edge register present, single request line). The other has `HAS_ANYEDGE=0` and `SPLIT_IRQ=1`. Comparing the two on the same stimulus shows the any-edge override next to plain mode decoding, and a single interrupt on pin 16 next to the upper split line. The sweep covers all four modes, both any-edge settings and two transition directions on four pins, two of which are outputs. The expected status comes from a per-pin formula over the old level, the new level and the direction.

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter bit HAS_ANYEDGE = 1'b1,
  parameter bit SPLIT_IRQ   = 1'b0,
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  input  logic [31:0]   pin_in,
  output logic [31:0]   pin_out,
  output logic [31:0]   pin_oe,
  output logic [1:0]    irq
);
  localparam int NP = 32;
  localparam int WA = AW - 2;
  localparam logic [WA-1:0] A_DATA = WA'(0);
  localparam logic [WA-1:0] A_DIR  = WA'(1);
  localparam logic [WA-1:0] A_PAD  = WA'(2);
  localparam logic [WA-1:0] A_MLO  = WA'(3);
  localparam logic [WA-1:0] A_MHI  = WA'(4);
  localparam logic [WA-1:0] A_MASK = WA'(5);
  localparam logic [WA-1:0] A_STAT = WA'(6);
  localparam logic [WA-1:0] A_AE   = WA'(7);

  logic [NP-1:0] sync_q [SYNC_STAGES];
  logic [NP-1:0] samp, psr, dr, gdir, imr, isr, ae, set_vec, clr;
  logic [31:0]   mode_lo, mode_hi, rmux;
  logic [2*NP-1:0] mode_all;
  logic [WA-1:0] word;
  logic aligned, mapped, wr_ok;

  assign word     = bus_addr[AW-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign mapped   = aligned && ((word < A_AE) || (word == A_AE && HAS_ANYEDGE));
  assign wr_ok    = bus_wr && mapped;
  assign clr      = (wr_ok && word == A_STAT) ? bus_wdata : '0;
  assign samp     = sync_q[SYNC_STAGES-1];
  assign mode_all = {mode_hi, mode_lo};
  assign pin_oe   = gdir;
  assign pin_out  = dr & gdir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NP; i++) begin
      logic [1:0] md;
      logic chg, hit;
      md  = mode_all[2*i +: 2];
      chg = samp[i] ^ psr[i];
      if (ae[i])      hit = chg;
      else if (md[1]) hit = chg && (samp[i] != md[0]);
      else            hit = (samp[i] == md[0]);
      set_vec[i] = hit && !gdir[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr <= '0; gdir <= '0; mode_lo <= '0; mode_hi <= '0;
      imr <= '0; isr <= '0; psr <= '0;
    end else begin
      if (wr_ok && word == A_DATA) dr      <= bus_wdata;
      if (wr_ok && word == A_DIR)  gdir    <= bus_wdata;
      if (wr_ok && word == A_MLO)  mode_lo <= bus_wdata;
      if (wr_ok && word == A_MHI)  mode_hi <= bus_wdata;
      if (wr_ok && word == A_MASK) imr     <= bus_wdata;
      psr <= samp;
      isr <= (isr & ~clr) | set_vec;
    end
  end

  generate
    if (HAS_ANYEDGE) begin : g_ae
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ae <= '0;
        else if (wr_ok && word == A_AE) ae <= bus_wdata;
      end
    end else begin : g_no_ae
      assign ae = '0;
    end
  endgenerate

  always_comb begin
    case (word)
      A_DATA:  rmux = (dr & gdir) | (psr & ~gdir);
      A_DIR:   rmux = gdir;
      A_PAD:   rmux = psr & ~gdir;
      A_MLO:   rmux = mode_lo;
      A_MHI:   rmux = mode_hi;
      A_MASK:  rmux = imr;
      A_STAT:  rmux = isr;
      A_AE:    rmux = ae;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_rd && mapped) ? rmux : '0;
      bus_err   <= (bus_rd || bus_wr) && !mapped;
    end
  end

  generate
    if (SPLIT_IRQ) begin : g_split
      assign irq[0] = |(isr[15:0]  & imr[15:0]);
      assign irq[1] = |(isr[31:16] & imr[31:16]);
    end else begin : g_single
      assign irq[0] = |(isr & imr);
      assign irq[1] = 1'b0;
    end
  endgenerate

  p_irq_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> irq == 2'b00);

  p_output_pins_never_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr)) & $past(gdir)) == '0);

  p_clear_only_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (~isr & $past(isr) & ~$past(clr)) == '0);

  p_err_follows_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd || bus_wr));

  p_bad_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && $past(bus_rd)) |-> bus_rdata == '0);
endmodule

// File: tb/gpio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata0, rdata1, pout0, pout1, poe0, poe1;
  logic        err0, err1;
  logic [1:0]  irq0, irq1;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (.clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .bus_err(err0), .pin_in(pin_in),
    .pin_out(pout0), .pin_oe(poe0), .irq(irq0));

  gpio_ctrl #(.HAS_ANYEDGE(1'b0), .SPLIT_IRQ(1'b1)) u_gpio_ctrl_alt (.clk(clk), .rst_n(rst_n),
    .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1),
    .bus_err(err1), .pin_in(pin_in), .pin_out(pout1), .pin_oe(poe1), .irq(irq1));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [5:0] a, output logic [31:0] r0, output logic [31:0] r1,
                        output logic e0, output logic e1);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    r0 = rdata0; r1 = rdata1; e0 = err0; e1 = err1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(int m, logic [31:0] aev, logic [31:0] o,
                                           logic [31:0] n, logic [31:0] d);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      if (aev[i])        r[i] = o[i] ^ n[i];
      else if (m == 2)   r[i] = !o[i] && n[i];
      else if (m == 3)   r[i] = o[i] && !n[i];
      else if (m == 1)   r[i] = o[i] || n[i];
      else               r[i] = !o[i] || !n[i];
    end
    return r & ~d;
  endfunction

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] r0, r1, old_v, new_v, aev;
    logic e0, e1;
    int pins[4] = '{0, 5, 16, 27};
    localparam logic [31:0] DIRV = 32'h0F0000F0;

    idle(3); rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq0", {30'd0, irq0}, 32'd0);
    chk("R1 irq1", {30'd0, irq1}, 32'd0);
    chk("R1 oe", poe0, 32'd0);
    chk("R1 out", pout0, 32'd0);
    for (int k = 0; k < 8; k++) begin
      if (k != 6) begin
        rd_reg(6'(4*k), r0, r1, e0, e1);
        chk("R1 reg inst0", r0, 32'd0);
        chk("R1 reg inst1", r1, 32'd0);
      end
    end
    // R4 low-level default mode with inputs low
    idle(4);
    rd_reg(6'h18, r0, r1, e0, e1);
    chk("R4 low-level after reset", r0, 32'hFFFFFFFF);

    // R2 output drive
    wr_reg(6'h00, 32'hA5A53C3C);
    wr_reg(6'h04, 32'hFFFF0000);
    chk("R2 pin_out", pout0, 32'hA5A50000);
    chk("R2 pin_oe", poe1, 32'hFFFF0000);
    // R3 read mux
    pin_in = 32'h12345678;
    idle(4);
    rd_reg(6'h00, r0, r1, e0, e1);
    chk("R3 data read", r0, 32'hA5A55678);
    rd_reg(6'h08, r0, r1, e0, e1);
    chk("R3 pad read", r1, 32'h00005678);

    // R4 R5 R6 R7 sweep
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 2; a++)
        for (int pt = 0; pt < 2; pt++)
          for (int k = 0; k < 4; k++) begin
            aev   = a ? 32'hFFFFFFFF : 32'h0;
            old_v = pt ? 32'hFFFFFFFF : 32'h0;
            new_v = pt ? ~(32'd1 << pins[k]) : (32'd1 << pins[k]);
            pin_in = old_v;
            wr_reg(6'h0C, {16{m[1:0]}});
            wr_reg(6'h10, {16{m[1:0]}});
            wr_reg(6'h1C, aev);
            wr_reg(6'h04, DIRV);
            idle(4);
            wr_reg(6'h18, 32'hFFFFFFFF);
            idle(1);
            pin_in = new_v;
            idle(4);
            rd_reg(6'h18, r0, r1, e0, e1);
            chk("R4 R5 R6 R7 status anyedge build", r0, exp_stat(m, aev, old_v, new_v, DIRV));
            chk("R4 R5 R7 status plain build", r1, exp_stat(m, 32'h0, old_v, new_v, DIRV));
          end

    // R11 any-edge register absent in alternate build
    rd_reg(6'h1C, r0, r1, e0, e1);
    chk("R11 ae present", r0, 32'hFFFFFFFF);
    chk("R11 ae absent reads 0", r1, 32'd0);
    chk("R11 err absent", {31'd0, e1}, 32'd1);
    chk("R11 err present", {31'd0, e0}, 32'd0);

    // R12 unmapped and misaligned
    wr_reg(6'h00, 32'h00C0FFEE);
    wr_reg(6'h20, 32'hDEADBEEF);
    wr_reg(6'h02, 32'hDEADBEEF);
    rd_reg(6'h24, r0, r1, e0, e1);
    chk("R12 unmapped read 0", r0, 32'd0);
    chk("R12 unmapped err", {31'd0, e0}, 32'd1);
    idle(1);
    chk("R12 err one cycle", {31'd0, err0}, 32'd0);
    wr_reg(6'h04, 32'hFFFFFFFF);
    rd_reg(6'h00, r0, r1, e0, e1);
    chk("R12 write ignored", r0, 32'h00C0FFEE);

    // R10 re-evaluation on config write
    wr_reg(6'h1C, 32'h0);
    wr_reg(6'h04, 32'h0);
    pin_in = 32'hFFFFFFFF;
    wr_reg(6'h0C, 32'hAAAAAAAA);
    wr_reg(6'h10, 32'hAAAAAAAA);
    idle(4);
    wr_reg(6'h18, 32'hFFFFFFFF);
    rd_reg(6'h18, r0, r1, e0, e1);
    chk("R10 cleared", r0, 32'd0);
    wr_reg(6'h0C, 32'h55555555);
    rd_reg(6'h18, r0, r1, e0, e1);
    chk("R10 level set on write", r0, 32'h0000FFFF);
    wr_reg(6'h10, 32'hFFFFFFFF);
    rd_reg(6'h18, r0, r1, e0, e1);
    chk("R10 edge no set on write", r1, 32'h0000FFFF);

    // R5 latency, R9 irq combine
    pin_in = 32'h0;
    wr_reg(6'h0C, 32'hAAAAAAAA);
    wr_reg(6'h10, 32'hAAAAAAAA);
    idle(4);
    wr_reg(6'h18, 32'hFFFFFFFF);
    wr_reg(6'h14, 32'h00010000);
    pin_in = 32'h00010000;
    idle(2);
    chk("R5 irq not before edge 3", {28'd0, irq0, irq1}, 32'd0);
    idle(1);
    chk("R5 R9 single line", {30'd0, irq0}, 32'd1);
    chk("R5 R9 split upper line", {30'd0, irq1}, 32'd2);
    wr_reg(6'h14, 32'h0);
    chk("R9 masked", {28'd0, irq0, irq1}, 32'd0);
    wr_reg(6'h14, 32'h00010000);
    // R8 write-one-to-clear
    wr_reg(6'h18, 32'h0);
    rd_reg(6'h18, r0, r1, e0, e1);
    chk("R8 zero write keeps", r0, 32'h00010000);
    wr_reg(6'h18, 32'h00010000);
    rd_reg(6'h18, r0, r1, e0, e1);
    chk("R8 cleared", r0, 32'd0);
    chk("R8 irq dropped", {28'd0, irq0, irq1}, 32'd0);
    wr_reg(6'h10, 32'hAAAAAAA9);
    idle(1);
    wr_reg(6'h18, 32'hFFFFFFFF);
    rd_reg(6'h18, r0, r1, e0, e1);
    chk("R8 active level beats clear", r0, 32'h00010000);
    chk("R9 split line level", {30'd0, irq1}, 32'd2);

    finish_up();
  end
endmodule